// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the command layer behind a serial memory front end. The front end delivers whole received bytes and tells the engine when the chip-select window opens and closes. On a close it also says whether a partial byte was pending. The engine decodes the first byte of each window as an opcode and runs the matching transaction on a 4096 x 8 synchronous array that it holds internally. The transactions are a sequential read, a page write through a 32-byte buffer, setting or clearing the write-enable latch, and reading or writing a status byte. The engine offers transmit bytes back to the front end. The front end takes each one with a pulse once it has been shifted out.

A write is only staged while the window is open. It takes effect when the window closes on a whole byte, and that close starts a self-timed busy period counted in system clocks. During the busy period the staged page is copied into the array, one slot per cycle, and only the slots that were actually received are copied. A neighbouring protection block watches the page base that the engine exposes and the status byte. It answers with two lock inputs, which the engine samples at the close.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: Opcodes are 0x03 read, 0x02 write, 0x06 latch set, 0x04 latch clear, 0x05 status read and 0x01 status write. Any other first byte makes the engine ignore the rest of that window: it offers no transmit byte and changes no state.
- R2: Read and write take two address bytes, high byte first. Only the low 12 bits of that 16-bit value are used, so the top four bits have no effect.
- R3: A read offers the byte at the address, then the byte at the next address after each take pulse. The address wraps from 0xFFF to 0x000, and the read lasts until the window closes.
- R4: Write data bytes fill the 32-byte page at consecutive offsets that wrap within the page, so a 33rd byte overwrites the first. When the write completes, only the received offsets change in the array.
- R5: A write commits only if all of these hold at the close: at least one whole data byte was received, no partial byte is pending, the latch is set and array_locked is low. Otherwise nothing is written and the latch keeps its value. chk_addr shows the base of the addressed page while the data bytes arrive.
- R6: Latch set and latch clear act only when the window closes after exactly one whole byte. Extra bytes or a partial byte cancel them.
- R7: A committed write or status write raises busy on the cycle after the close. Busy then stays high for exactly WR_CYCLES cycles and is reported as status bit 0.
- R8: While busy is high, only status read is honoured. Read, write, latch and status-write commands in that period have no effect.
- R9: After reset, busy, the latch and the status byte are all zero and no transmit byte is offered. The latch clears when a write or status write completes.
- R10: Status write commits only with exactly one data byte, the latch set and status_locked low. On completion it copies data bits 7, 3 and 2 into status bits 7, 3 and 2. The status byte is {bit7, 000, bit3, bit2, latch, busy}.
- R11: Status read offers the live status byte continuously, repeating it after each take pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_start | input | 1 | Pulse: select window opened |
| sel_end | input | 1 | Pulse: select window closed |
| end_partial | input | 1 | With sel_end: bits of an unfinished byte were pending |
| rx_valid | input | 1 | Pulse: a whole byte was received |
| rx_byte | input | 8 | Received byte |
| tx_take | input | 1 | Pulse: the offered byte has been shifted out |
| tx_valid | output | 1 | A transmit byte is offered (otherwise the line floats) |
| tx_byte | output | 8 | Offered transmit byte |
| busy | output | 1 | Self-timed write in progress |
| array_locked | input | 1 | Protection verdict for the page at chk_addr |
| status_locked | input | 1 | Protection verdict for status writes |
| chk_addr | output | ADDR_W | Base address of the page being written |
| stat_byte | output | 8 | Current status byte |

## Verification
The bench targets the close conditions. These are a close with a pending partial byte, a write with address but no data, a latch command followed by a stray byte, and a write without the latch or against an active lock. A design that qualifies the close loosely would raise busy and corrupt memory in these cases. Page wrap is exercised from offset 30 and with 34 bytes, after the page was pre-filled. A design that wrote the whole buffer back or advanced into the next page would change untouched bytes. The bench reads across 0xFFF with an address whose top nibble is set, to catch a missing wrap or an address using all 16 bits. It also issues reads and writes during busy, to catch a design that lets array traffic through while the copy is running.

// File: rtl/eecmd_pkg.sv
package eecmd_pkg;

    localparam logic [7:0] OPC_RD      = 8'h03;
    localparam logic [7:0] OPC_WR      = 8'h02;
    localparam logic [7:0] OPC_WLOCK   = 8'h04;
    localparam logic [7:0] OPC_WUNLOCK = 8'h06;
    localparam logic [7:0] OPC_SRD     = 8'h05;
    localparam logic [7:0] OPC_SWR     = 8'h01;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_OPC,
        ST_AH,
        ST_AL,
        ST_RD,
        ST_WR,
        ST_SR,
        ST_SRX,
        ST_ONE,
        ST_STAT,
        ST_SKIP
    } cmd_st_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_PAGE,
        PEND_STAT
    } pend_e;

endpackage

// File: rtl/eecmd_array.sv
module eecmd_array #(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/eecmd_pagebuf.sv
module eecmd_pagebuf #(
    parameter int unsigned PW = 5,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [PW-1:0] wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_off,
    output logic [DW-1:0] rd_data,
    output logic          rd_mark
);
    localparam int unsigned NB = 1 << PW;

    logic [DW-1:0] data_q [NB];
    logic [DW-1:0] data_d [NB];
    logic [NB-1:0] mark_q, mark_d;

    always_comb begin
        data_d = data_q;
        mark_d = mark_q;
        if (clr) begin
            mark_d = '0;
        end
        if (wr) begin
            data_d[wr_off] = wr_data;
            mark_d[wr_off] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_q <= '0;
        end else begin
            mark_q <= mark_d;
        end
    end

    assign rd_data = data_q[rd_off];
    assign rd_mark = mark_q[rd_off];

    // R4: a slot is never cleared and filled in the same cycle
    a_r4_clr_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && wr));

endmodule

// File: rtl/eecmd_timer.sv
module eecmd_timer #(
    parameter int unsigned CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (start) begin
            d.run = 1'b1;
            d.cnt = CW'(CYCLES - 1);
        end else if (q.run) begin
            if (q.cnt == '0) begin
                d.run = 1'b0;
                done  = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.run;

    // R7: a new cycle is never started on top of a running one
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.run);

    // R7: the count never exceeds the programmed length
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (q.cnt < CW'(CYCLES)));

endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine
    import eecmd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned PAGE_W    = 5,
    parameter int unsigned WR_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_start,
    input  logic              sel_end,
    input  logic              end_partial,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_take,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              busy,
    input  logic              array_locked,
    input  logic              status_locked,
    output logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        stat_byte
);
    localparam int unsigned PG_W = ADDR_W - PAGE_W;

    typedef struct packed {
        cmd_st_e             st;
        logic [7:0]          op;
        logic [ADDR_W-1:0]   addr;
        logic                got;
        logic                rd_wait;
        logic [2:0]          sr_in;
        logic [2:0]          sr_new;
        logic                wel;
        logic                guard;
        logic [1:0]          zone;
        pend_e               pend;
        logic                wb_on;
        logic [PAGE_W-1:0]   wb_idx;
        logic [PG_W-1:0]     wpage;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_OFF, pend: PEND_NONE, default: '0};

    eng_t q, d;

    logic              tm_start, tm_done;
    logic              pb_clr, pb_wr;
    logic [7:0]        pb_data;
    logic              pb_mark;
    logic              mem_we;
    logic [7:0]        mem_rdata;

    eecmd_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tm_start),
        .busy  (busy),
        .done  (tm_done)
    );

    eecmd_pagebuf #(.PW(PAGE_W), .DW(8)) u_pagebuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pb_clr),
        .wr      (pb_wr),
        .wr_off  (q.addr[PAGE_W-1:0]),
        .wr_data (rx_byte),
        .rd_off  (q.wb_idx),
        .rd_data (pb_data),
        .rd_mark (pb_mark)
    );

    assign mem_we = q.wb_on && pb_mark;

    eecmd_array #(.AW(ADDR_W), .DW(8)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({q.wpage, q.wb_idx}),
        .wdata (pb_data),
        .raddr (q.addr),
        .rdata (mem_rdata)
    );

    always_comb begin
        d        = q;
        tm_start = 1'b0;
        pb_clr   = 1'b0;
        pb_wr    = 1'b0;

        if (q.rd_wait) begin
            d.rd_wait = 1'b0;
        end

        // copy of the staged page, one slot per cycle
        if (q.wb_on) begin
            d.wb_idx = q.wb_idx + 1'b1;
            if (&q.wb_idx) begin
                d.wb_on = 1'b0;
            end
        end

        if (tm_done) begin
            d.wel = 1'b0;
            if (q.pend == PEND_STAT) begin
                d.guard = q.sr_new[2];
                d.zone  = q.sr_new[1:0];
            end
            d.pend = PEND_NONE;
        end

        if (sel_start) begin
            d.st  = ST_OPC;
            d.got = 1'b0;
        end else if (sel_end) begin
            d.st = ST_OFF;
            if (!end_partial) begin
                case (q.st)
                    ST_ONE: d.wel = (q.op == OPC_WUNLOCK);
                    ST_WR: begin
                        if (q.got && q.wel && !array_locked) begin
                            tm_start = 1'b1;
                            d.pend   = PEND_PAGE;
                            d.wb_on  = 1'b1;
                            d.wb_idx = '0;
                            d.wpage  = q.addr[ADDR_W-1:PAGE_W];
                        end
                    end
                    ST_SRX: begin
                        if (q.wel && !status_locked) begin
                            tm_start = 1'b1;
                            d.pend   = PEND_STAT;
                            d.sr_new = q.sr_in;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (rx_valid) begin
            case (q.st)
                ST_OPC: begin
                    d.op = rx_byte;
                    if (busy) begin
                        d.st = (rx_byte == OPC_SRD) ? ST_STAT : ST_SKIP;
                    end else begin
                        case (rx_byte)
                            OPC_RD, OPC_WR:       d.st = ST_AH;
                            OPC_WUNLOCK, OPC_WLOCK: d.st = ST_ONE;
                            OPC_SRD:              d.st = ST_STAT;
                            OPC_SWR:              d.st = ST_SR;
                            default:              d.st = ST_SKIP;
                        endcase
                    end
                end
                ST_AH: begin
                    d.addr = ADDR_W'({q.addr, rx_byte});
                    d.st   = ST_AL;
                end
                ST_AL: begin
                    d.addr = ADDR_W'({q.addr, rx_byte});
                    if (q.op == OPC_RD) begin
                        d.st      = ST_RD;
                        d.rd_wait = 1'b1;
                    end else begin
                        d.st   = ST_WR;
                        pb_clr = 1'b1;
                        d.got  = 1'b0;
                    end
                end
                ST_WR: begin
                    pb_wr                 = 1'b1;
                    d.addr[PAGE_W-1:0]    = q.addr[PAGE_W-1:0] + 1'b1;
                    d.got                 = 1'b1;
                end
                ST_SR: begin
                    d.sr_in = {rx_byte[7], rx_byte[3:2]};
                    d.st    = ST_SRX;
                end
                ST_SRX, ST_ONE: d.st = ST_SKIP;
                default: ;
            endcase
        end else if (tx_take && (q.st == ST_RD) && !q.rd_wait) begin
            d.addr    = q.addr + 1'b1;
            d.rd_wait = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= ENG_RST;
        end else begin
            q <= d;
        end
    end

    assign stat_byte = {q.guard, 3'b000, q.zone, q.wel, busy};
    assign tx_valid  = (q.st == ST_STAT) || ((q.st == ST_RD) && !q.rd_wait);
    assign tx_byte   = (q.st == ST_STAT) ? stat_byte : mem_rdata;
    assign chk_addr  = {q.addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};

    // R7: busy only rises right after a window close
    a_r7_rise_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sel_end));

    // R5: no commit on a close with a partial byte
    a_r5_whole_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!end_partial));

    // R9: the latch is clear once a cycle has ended
    a_r9_wel_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !q.wel);

    // R8: during busy the only offered byte is the status byte (bit 0 set)
    a_r8_busy_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_valid) |-> tx_byte[0]);

    // R4: the page copy runs only inside the busy period
    a_r4_wb_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q.wb_on |-> busy);

    // R3: a take during a read advances the pointer by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_RD) && tx_take && !q.rd_wait && !sel_start && !sel_end && !rx_valid)
        |=> (q.addr == ADDR_W'($past(q.addr) + 1'b1)));

endmodule

// File: tb/test_eeprom_cmd_engine.sv
module test_eeprom_cmd_engine;

    localparam int WR = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_start = 1'b0, sel_end = 1'b0, end_partial = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_take = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        busy;
    logic        array_locked = 1'b0, status_locked = 1'b0;
    logic [11:0] chk_addr;
    logic [7:0]  stat_byte;

    eeprom_cmd_engine #(.ADDR_W(12), .PAGE_W(5), .WR_CYCLES(WR)) i_eeprom_cmd_engine (
        .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .sel_end(sel_end),
        .end_partial(end_partial), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_take(tx_take), .tx_valid(tx_valid), .tx_byte(tx_byte), .busy(busy),
        .array_locked(array_locked), .status_locked(status_locked),
        .chk_addr(chk_addr), .stat_byte(stat_byte)
    );

    always #5 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    // behavioural reference model
    int m_mem [4096];
    int m_left = 0;
    bit m_wel = 0, m_guard = 0;
    int m_zone = 0;
    bit go_commit = 0, op_busy = 0;
    int pa[$], pd[$];
    bit psr_on = 0;
    int psr = 0;
    int sent[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int m_status();
        return (int'(m_guard) << 7) | (m_zone << 2) | (int'(m_wel) << 1) | ((m_left > 0) ? 1 : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0;
        end else begin
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    foreach (pa[i]) m_mem[pa[i]] = pd[i];
                    pa.delete(); pd.delete();
                    if (psr_on) begin
                        m_guard = psr[7];
                        m_zone  = (psr >> 2) & 3;
                        psr_on  = 0;
                    end
                    m_wel = 0;
                end
            end
            if (sel_end && go_commit) begin
                m_left    = WR;
                go_commit = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished)
            chk(busy === (m_left > 0), "R7 busy length", busy, (m_left > 0));
    end

    task automatic win_open();
        @(negedge clk); sel_start = 1'b1;
        @(negedge clk); sel_start = 1'b0;
        sent.delete();
    endtask

    task automatic push(input int b);
        if (sent.size() == 0) op_busy = (m_left > 0);
        rx_valid = 1'b1; rx_byte = 8'(b);
        sent.push_back(b & 255);
        @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic win_close(input bit partial);
        int n, base;
        n = sent.size();
        if (!partial && n > 0 && !op_busy) begin
            if (n == 1 && sent[0] == 6) m_wel = 1;
            if (n == 1 && sent[0] == 4) m_wel = 0;
            if (sent[0] == 2 && n >= 4 && m_wel && !array_locked) begin
                base = ((sent[1] << 8) | sent[2]) & 12'hFFF;
                for (int i = 3; i < n; i++) begin
                    pa.push_back((base & 12'hFE0) | ((base + i - 3) & 31));
                    pd.push_back(sent[i]);
                end
                go_commit = 1;
            end
            if (sent[0] == 1 && n == 2 && m_wel && !status_locked) begin
                psr_on = 1; psr = sent[1]; go_commit = 1;
            end
        end
        sel_end = 1'b1; end_partial = partial;
        @(negedge clk); sel_end = 1'b0; end_partial = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmd1(input int op);
        win_open(); push(op); win_close(0);
    endtask

    task automatic wr_page(input int a, input int n, input int seed);
        win_open(); push(2); push(a >> 8); push(a & 255);
        for (int i = 0; i < n; i++) push((seed + i * 7) & 255);
        win_close(0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rdsr_chk(input string tag);
        int e;
        win_open(); push(5);
        e = m_status();
        chk(tx_valid === 1'b1 && tx_byte == 8'(e), tag, tx_byte, e);
        win_close(0);
    endtask

    task automatic rd_run(input int a16, input int n, input string tag);
        int w, e, a;
        a = a16 & 12'hFFF;
        win_open(); push(3); push(a16 >> 8); push(a16 & 255);
        for (int i = 0; i < n; i++) begin
            w = 0;
            while (!tx_valid && w < 10) begin @(negedge clk); w++; end
            e = m_mem[(a + i) & 12'hFFF];
            chk(tx_valid === 1'b1 && tx_byte == 8'(e), tag, tx_byte, e);
            tx_take = 1'b1;
            @(negedge clk); tx_take = 1'b0;
        end
        win_close(0);
    endtask

    task automatic rd_none(input string tag);
        bit seen;
        seen = 0;
        win_open(); push(3); push(8'h02); push(8'h10);
        for (int i = 0; i < 4; i++) begin
            if (tx_valid) seen = 1;
            @(negedge clk);
        end
        chk(!seen, tag, seen, 0);
        win_close(0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        foreach (m_mem[i]) m_mem[i] = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk(busy === 1'b0 && tx_valid === 1'b0, "R9 reset outputs", {busy, tx_valid}, 0);
        chk(stat_byte == 8'h00, "R9 reset status", stat_byte, 0);
        rdsr_chk("R9 status read after reset");

        // R6 latch set / clear
        cmd1(6); rdsr_chk("R6 latch set");
        chk(stat_byte == 8'h02, "R6 latch bit 1", stat_byte, 2);
        cmd1(4); rdsr_chk("R6 latch clear");
        win_open(); push(6); push(0); win_close(0);
        rdsr_chk("R6 stray byte cancels set");
        win_open(); push(6); win_close(1);
        rdsr_chk("R6 partial byte cancels set");

        // R2/R4/R7/R8 write with top nibble set
        cmd1(6);
        wr_page(16'h1210, 3, 8'hA1);
        rdsr_chk("R7 status during busy");
        chk(stat_byte[0] == 1'b1, "R7 busy in status bit 0", stat_byte, 1);
        rd_none("R8 read ignored while busy");
        win_open(); push(2); push(8'h02); push(8'h10); push(8'h77); win_close(0);
        wait_idle();
        chk(busy === 1'b0, "R8 write during busy did not restart", busy, 0);
        rdsr_chk("R9 latch cleared on completion");
        rd_run(16'h0210, 3, "R2 read back");

        // R4 page fill then wrap
        cmd1(6); wr_page(16'h0020, 32, 8'h40); wait_idle();
        cmd1(6); wr_page(16'h003E, 4, 8'hE0); wait_idle();
        rd_run(16'h0020, 32, "R4 wrap keeps untouched bytes");
        cmd1(6); wr_page(16'h0100, 34, 8'h11); wait_idle();
        rd_run(16'h0100, 32, "R4 overflow overwrites first slots");

        // R5 close conditions
        cmd1(6);
        win_open(); push(2); push(8'h03); push(8'h00); push(8'h55); win_close(1);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R5 partial close no commit", busy, 0);
        rdsr_chk("R5 latch kept after abort");
        win_open(); push(2); push(8'h03); push(8'h00); win_close(0);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R5 no data no commit", busy, 0);
        array_locked = 1'b1;
        win_open(); push(2); push(8'h05); push(8'h17);
        chk(chk_addr == 12'h500, "R5 page base exposed", chk_addr, 12'h500);
        push(8'h66); win_close(0);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R5 locked no commit", busy, 0);
        array_locked = 1'b0;
        cmd1(4);
        wr_page(16'h0210, 1, 8'h99);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R5 no latch no commit", busy, 0);
        rd_run(16'h0210, 1, "R5 data unchanged");

        // R3 wrap across top of array
        cmd1(6); wr_page(16'h0FFE, 2, 8'h30); wait_idle();
        cmd1(6); wr_page(16'h0000, 2, 8'h50); wait_idle();
        rd_run(16'hFFFE, 4, "R3 rollover read");

        // R10 status write
        cmd1(6);
        win_open(); push(1); push(8'hFF); win_close(0);
        rdsr_chk("R10 old status during busy");
        wait_idle();
        rdsr_chk("R10 status after write");
        chk(stat_byte == 8'h8C, "R10 stored bits 7,3,2", stat_byte, 8'h8C);
        cmd1(6);
        status_locked = 1'b1;
        win_open(); push(1); push(8'h00); win_close(0);
        status_locked = 1'b0;
        rdsr_chk("R10 locked status write ignored");
        win_open(); push(1); push(8'h00); push(8'h00); win_close(0);
        rdsr_chk("R10 two data bytes ignored");
        cmd1(4);

        // R1 unknown opcode
        win_open(); push(8'h07);
        chk(tx_valid === 1'b0, "R1 no output on unknown opcode", tx_valid, 0);
        push(6); win_close(0);
        rdsr_chk("R1 rest of window ignored");

        // R11 status stream repeats
        win_open(); push(5);
        chk(tx_valid === 1'b1 && tx_byte == 8'h8C, "R11 first status byte", tx_byte, 8'h8C);
        tx_take = 1'b1; @(negedge clk); tx_take = 1'b0; @(negedge clk);
        chk(tx_valid === 1'b1 && tx_byte == 8'h8C, "R11 repeated status byte", tx_byte, 8'h8C);
        win_close(0);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule